// File: doc/BRIEF.md
# Receive Buffer Chain Scatter Engine

The engine places one accepted receive frame, followed by its 4-byte check sequence, into a chain of receive buffers. Frame bytes arrive one per cycle over a valid/ready stream. Buffer sizes arrive in chain order over a second valid/ready port. For every byte placed, the engine issues a write request naming the buffer index, the offset inside that buffer and the byte. Frames shorter than 60 bytes are padded with zeros before the check sequence. The check sequence is supplied as a 32-bit word at frame start and is placed most significant byte first.

When it leaves a buffer, the engine writes back a count word for that buffer. The count word holds the number of bytes written, a filled flag, and an end-of-frame flag on the buffer that received the final byte. When the frame is finished, the engine pulses a completion event together with an interrupt and presents a status word. Two frame-descriptor flags can halt further reception after the current frame. A suspend request also raises an event saying that the receive unit left the active state. If the chain runs out before every byte is placed, the frame is truncated, an overflow flag is raised, and the rest of the incoming frame is drained.

Top module: `rx_scatter`

## Requirements
- R1: After reset, idle_o is 1 and in_ready_o, buf_ready_o, wr_valid_o, cnt_valid_o and done_o are all 0.
- R2: A buffer's capacity is buf_size_i[13:0]. buf_size_i[15] marks the last buffer of the chain. buf_size_i[14] has no effect.
- R3: The byte stream is the frame data, then any zero padding, then the check sequence. Each buffer takes the next min(capacity, bytes remaining) bytes of that stream at offsets 0, 1, 2 and so on. The check sequence may be split across two buffers.
- R4: The check sequence is placed big-endian: fcs_i[31:24] first and fcs_i[7:0] last.
- R5: A frame shorter than 60 bytes is extended with zero bytes to 60 bytes before the check sequence.
- R6: Each buffer that is taken receives one count word. Bits 13:0 hold the bytes written, bit 14 is always 1, and bit 15 is 1 only on the buffer that holds the last stream byte. No buffer size is taken after that buffer.
- R7: A buffer with capacity 0 receives no writes. Its count word is 0x4000, and placement continues in the next buffer.
- R8: If a buffer flagged last fills before the stream ends, the frame is truncated. Its count word has bit 15 clear, ovf_o is 1 during done_o, and the remaining input bytes are accepted and discarded.
- R9: Completion pulses done_o and irq_o for one cycle, with stat_o = 0xA000 OR (bcast_i ? 0x0001 : 0).
- R10: If fd_susp_i was set at start, rnr_o pulses with done_o and halt_o rises. While halt_o is 1, start_i is ignored and no byte or buffer is taken, until resume_i is pulsed.
- R11: If fd_eol_i was set at start, halt_o rises at completion without rnr_o, and it is cleared by resume_i in the same way.
- R12: At most one byte is accepted per cycle. A gap on in_valid_i or buf_valid_i stalls the engine without losing or reordering bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame; accepted while idle_o is 1 |
| frame_len_i | input | LEN_W | Frame data length in bytes, without the check sequence |
| fcs_i | input | 32 | Check sequence value |
| bcast_i | input | 1 | Broadcast indicator for the status word |
| fd_susp_i | input | 1 | Frame descriptor asks to suspend after this frame |
| fd_eol_i | input | 1 | Frame descriptor is the last of the list |
| resume_i | input | 1 | Clears the halted state |
| idle_o | output | 1 | Ready to accept start_i |
| in_valid_i | input | 1 | Frame byte valid |
| in_byte_i | input | 8 | Frame byte |
| in_ready_o | output | 1 | Frame byte accepted this cycle when valid |
| buf_valid_i | input | 1 | Next buffer size valid |
| buf_size_i | input | 16 | Buffer size word |
| buf_ready_o | output | 1 | Buffer size accepted this cycle when valid |
| wr_valid_o | output | 1 | Write request |
| wr_buf_o | output | IDX_W | Buffer index within the chain |
| wr_off_o | output | 14 | Offset within the buffer |
| wr_byte_o | output | 8 | Byte to write |
| cnt_valid_o | output | 1 | Count word write-back |
| cnt_buf_o | output | IDX_W | Buffer index of the count word |
| cnt_word_o | output | 16 | Count with filled (bit 14) and end-of-frame (bit 15) flags |
| done_o | output | 1 | Frame-received event |
| irq_o | output | 1 | Interrupt pulse |
| stat_o | output | 16 | Frame status word, valid with done_o |
| ovf_o | output | 1 | Truncation flag, valid with done_o |
| rnr_o | output | 1 | Receive unit left the active state |
| halt_o | output | 1 | Reception halted |

## Verification
The assertions check, on every cycle, the rules that hold locally. Writes stay below the current buffer's capacity, and every count word carries the filled flag and never exceeds that capacity. An end-of-frame count word is followed by completion, with the fixed status bits present. Only one of write, write-back, fetch and completion is active at a time, and nothing is taken while halted. What only the directed scenarios can show is where each byte ends up. That covers padding, big-endian order of the check sequence, a split of that sequence across two buffers, exact-fit and zero-capacity buffers, truncation followed by draining, and the halt and resume behaviour. For each of these the bench compares the placement against a stream it builds itself.

// File: rtl/rx_scatter_pkg.sv
package rx_scatter_pkg;
  localparam int unsigned MIN_FRAME = 60;
  localparam int unsigned FCS_BYTES = 4;
  localparam int unsigned SZ_W      = 14;
  localparam int unsigned SZ_LAST   = 15;
  localparam int unsigned CNT_FILL  = 14;
  localparam int unsigned CNT_EOF   = 15;
  localparam logic [15:0] STAT_BASE = 16'hA000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FILL, ST_WB, ST_DRAIN, ST_DONE
  } st_e;
endpackage

// File: rtl/rx_stream_sel.sv
module rx_stream_sel
  import rx_scatter_pkg::*;
#(
  parameter int unsigned LEN_W = 14,
  localparam int unsigned POS_W = LEN_W + 1
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      fcs_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_byte_i,
  output logic             from_in_o,
  output logic             avail_o,
  output logic [7:0]       byte_o
);
  logic [POS_W-1:0] len_ext, data_end, fcs_idx;

  assign len_ext  = POS_W'(len_i);
  assign data_end = (len_ext < POS_W'(MIN_FRAME)) ? POS_W'(MIN_FRAME) : len_ext;
  assign fcs_idx  = pos_i - data_end;
  assign from_in_o = pos_i < len_ext;

  always_comb begin
    if (from_in_o) begin
      avail_o = in_valid_i;
      byte_o  = in_byte_i;
    end else if (pos_i < data_end) begin
      avail_o = 1'b1;
      byte_o  = 8'h00;
    end else begin
      avail_o = 1'b1;
      // check sequence goes out most significant byte first
      unique case (fcs_idx[1:0])
        2'd0:    byte_o = fcs_i[31:24];
        2'd1:    byte_o = fcs_i[23:16];
        2'd2:    byte_o = fcs_i[15:8];
        default: byte_o = fcs_i[7:0];
      endcase
    end
  end
endmodule

// File: rtl/rx_ru_state.sv
module rx_ru_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic susp_i,
  input  logic eol_i,
  input  logic resume_i,
  output logic halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         halt_o <= 1'b0;
    else if (done_i && (susp_i || eol_i)) halt_o <= 1'b1;
    else if (resume_i)                   halt_o <= 1'b0;
  end

  a_r11_halt_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(done_i));
  a_r10_resume_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !done_i) |=> !halt_o);
endmodule

// File: rtl/rx_scatter.sv
module rx_scatter
  import rx_scatter_pkg::*;
#(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [31:0]      fcs_i,
  input  logic             bcast_i,
  input  logic             fd_susp_i,
  input  logic             fd_eol_i,
  input  logic             resume_i,
  output logic             idle_o,
  input  logic             in_valid_i,
  input  logic [7:0]       in_byte_i,
  output logic             in_ready_o,
  input  logic             buf_valid_i,
  input  logic [15:0]      buf_size_i,
  output logic             buf_ready_o,
  output logic             wr_valid_o,
  output logic [IDX_W-1:0] wr_buf_o,
  output logic [13:0]      wr_off_o,
  output logic [7:0]       wr_byte_o,
  output logic             cnt_valid_o,
  output logic [IDX_W-1:0] cnt_buf_o,
  output logic [15:0]      cnt_word_o,
  output logic             done_o,
  output logic             irq_o,
  output logic [15:0]      stat_o,
  output logic             ovf_o,
  output logic             rnr_o,
  output logic             halt_o
);
  localparam int unsigned POS_W = LEN_W + 1;

  st_e              state_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      fcs_q;
  logic             bcast_q, susp_q, eol_q, last_q, ovf_q;
  logic [POS_W-1:0] pos_q, total_q, len_ext, start_end;
  logic [IDX_W-1:0] idx_q;
  logic [SZ_W-1:0]  off_q, cap_q;

  logic from_in, avail;
  logic [7:0] sel_byte;
  logic take, in_fire, stream_end;
  logic unused_sz;

  assign unused_sz = buf_size_i[CNT_FILL];
  assign len_ext   = POS_W'(len_q);
  assign start_end = ((POS_W'(frame_len_i) < POS_W'(MIN_FRAME)) ?
                      POS_W'(MIN_FRAME) : POS_W'(frame_len_i)) + POS_W'(FCS_BYTES);
  assign stream_end = (pos_q == total_q);

  rx_stream_sel #(.LEN_W(LEN_W)) i_sel (
    .pos_i      (pos_q),
    .len_i      (len_q),
    .fcs_i      (fcs_q),
    .in_valid_i (in_valid_i),
    .in_byte_i  (in_byte_i),
    .from_in_o  (from_in),
    .avail_o    (avail),
    .byte_o     (sel_byte)
  );

  rx_ru_state i_ru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_o),
    .susp_i   (susp_q),
    .eol_i    (eol_q),
    .resume_i (resume_i),
    .halt_o   (halt_o)
  );

  assign idle_o      = (state_q == ST_IDLE) && !halt_o;
  assign buf_ready_o = (state_q == ST_FETCH);
  assign in_ready_o  = ((state_q == ST_FILL) && from_in) ||
                       ((state_q == ST_DRAIN) && (pos_q < len_ext));
  assign in_fire     = in_ready_o && in_valid_i;
  assign take        = (state_q == ST_FILL) && avail;

  assign wr_valid_o  = take;
  assign wr_buf_o    = idx_q;
  assign wr_off_o    = off_q;
  assign wr_byte_o   = sel_byte;

  assign cnt_valid_o = (state_q == ST_WB);
  assign cnt_buf_o   = idx_q;
  assign cnt_word_o  = {stream_end, 1'b1, off_q};

  assign done_o = (state_q == ST_DONE);
  assign irq_o  = done_o;
  assign stat_o = STAT_BASE | {15'd0, bcast_q};
  assign ovf_o  = done_o && ovf_q;
  assign rnr_o  = done_o && susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      fcs_q   <= '0;
      bcast_q <= 1'b0;
      susp_q  <= 1'b0;
      eol_q   <= 1'b0;
      last_q  <= 1'b0;
      ovf_q   <= 1'b0;
      pos_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
      off_q   <= '0;
      cap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && !halt_o) begin
          len_q   <= frame_len_i;
          fcs_q   <= fcs_i;
          bcast_q <= bcast_i;
          susp_q  <= fd_susp_i;
          eol_q   <= fd_eol_i;
          total_q <= start_end;
          pos_q   <= '0;
          idx_q   <= '0;
          ovf_q   <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (buf_valid_i) begin
          cap_q   <= buf_size_i[SZ_W-1:0];
          last_q  <= buf_size_i[SZ_LAST];
          off_q   <= '0;
          state_q <= (buf_size_i[SZ_W-1:0] == '0) ? ST_WB : ST_FILL;
        end
        ST_FILL: if (take) begin
          pos_q <= pos_q + 1'b1;
          off_q <= off_q + 1'b1;
          if ((off_q + 1'b1 == cap_q) || (pos_q + 1'b1 == total_q)) state_q <= ST_WB;
        end
        ST_WB: begin
          if (stream_end) state_q <= ST_DONE;
          else if (last_q) begin
            ovf_q   <= 1'b1;
            state_q <= (pos_q < len_ext) ? ST_DRAIN : ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_DRAIN: if (in_fire) begin
          pos_q <= pos_q + 1'b1;
          if (pos_q + 1'b1 == len_ext) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_wr_within_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_off_o < cap_q));
  a_r6_cnt_filled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_valid_o |-> (cnt_word_o[CNT_FILL] && (cnt_word_o[SZ_W-1:0] <= cap_q)));
  a_r6_eof_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_valid_o && cnt_word_o[CNT_EOF]) |=> done_o);
  a_r9_done_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stat_o[15] && stat_o[13] && !wr_valid_o));
  a_r12_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_o, cnt_valid_o, buf_ready_o, done_o}));
  a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!buf_ready_o && !in_ready_o && !wr_valid_o));
endmodule

// File: tb/test_rx_scatter.sv
`timescale 1ns/1ps
module test_rx_scatter;
  localparam int LEN_W = 14;
  localparam int IDX_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, bcast_i = 0, fd_susp_i = 0, fd_eol_i = 0, resume_i = 0;
  logic [LEN_W-1:0] frame_len_i = '0;
  logic [31:0] fcs_i = '0;
  logic idle_o, in_valid_i = 0, in_ready_o, buf_valid_i = 0, buf_ready_o;
  logic [7:0] in_byte_i = '0, wr_byte_o;
  logic [15:0] buf_size_i = '0, cnt_word_o, stat_o;
  logic wr_valid_o, cnt_valid_o, done_o, irq_o, ovf_o, rnr_o, halt_o;
  logic [IDX_W-1:0] wr_buf_o, cnt_buf_o;
  logic [13:0] wr_off_o;

  always #2 clk_i = ~clk_i;

  rx_scatter #(.LEN_W(LEN_W), .IDX_W(IDX_W)) i_rx_scatter (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0]  frm [0:255];
  logic [15:0] sz [0:7];
  int nbuf;
  logic [7:0]  mem [0:7][0:127];
  logic [15:0] cntw [0:7];
  bit          cnt_seen [0:7];
  int wr_count, in_ptr, bptr, bad_wr;
  bit got_done, got_ovf, got_rnr, got_irq;
  logic [15:0] got_stat;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R12: watchdog expired, actual 0 expected 1");
    finish_run();
  end

  function automatic logic [7:0] exp_byte(input int len, input logic [31:0] fcs, input int p);
    int d = (len < 60) ? 60 : len;
    if (p < len) return frm[p];
    if (p < d) return 8'h00;
    return fcs[8*(3-(p-d)) +: 8];
  endfunction

  task automatic run(input int len, input logic [31:0] fcs, input bit bc,
                     input bit su, input bit eo, input bit gaps);
    for (int b = 0; b < 8; b++) begin
      cnt_seen[b] = 0; cntw[b] = '0;
      for (int o = 0; o < 128; o++) mem[b][o] = 8'hxx;
    end
    wr_count = 0; in_ptr = 0; bptr = 0; bad_wr = 0;
    got_done = 0; got_ovf = 0; got_rnr = 0; got_irq = 0; got_stat = '0;
    @(negedge clk_i);
    start_i = 1; frame_len_i = LEN_W'(len); fcs_i = fcs;
    bcast_i = bc; fd_susp_i = su; fd_eol_i = eo;
    @(negedge clk_i);
    start_i = 0;
    for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
      in_valid_i  = (in_ptr < len) && !(gaps && (cyc % 3 == 1));
      in_byte_i   = (in_ptr < len) ? frm[in_ptr] : 8'h00;
      buf_valid_i = (bptr < nbuf) && !(gaps && (cyc % 4 == 0));
      buf_size_i  = (bptr < nbuf) ? sz[bptr] : 16'h0;
      #1;
      if (wr_valid_o) begin
        wr_count++;
        if (wr_buf_o < 8 && wr_off_o < 128) mem[wr_buf_o][wr_off_o] = wr_byte_o;
        else bad_wr++;
      end
      if (cnt_valid_o && cnt_buf_o < 8) begin
        cnt_seen[cnt_buf_o] = 1; cntw[cnt_buf_o] = cnt_word_o;
      end
      if (in_ready_o && in_valid_i) in_ptr++;
      if (buf_ready_o && buf_valid_i) bptr++;
      if (done_o) begin
        got_done = 1; got_ovf = ovf_o; got_rnr = rnr_o;
        got_irq = irq_o; got_stat = stat_o;
      end
      @(negedge clk_i);
    end
    in_valid_i = 0; buf_valid_i = 0;
    chk(got_done, "R9 completion seen", got_done, 1);
  endtask

  // walks the chain independently and compares placement, counts and status
  task automatic check_frame(input int len, input logic [31:0] fcs, input bit bc);
    int t = ((len < 60) ? 60 : len) + 4;
    int p = 0, used = 0, mism = 0;
    for (int b = 0; b < nbuf; b++) begin
      int cap = int'(sz[b][13:0]);
      int c = (cap < t - p) ? cap : t - p;
      logic [15:0] ew = {(p + c == t), 1'b1, 14'(c)};
      chk(cnt_seen[b] && cntw[b] == ew, "R6 count word", cntw[b], ew);
      for (int o = 0; o < c; o++)
        if (mem[b][o] !== exp_byte(len, fcs, p + o)) mism++;
      p += c; used = b + 1;
      if (p == t || sz[b][15]) break;
    end
    chk(mism == 0 && bad_wr == 0, "R3 byte placement", mism, 0);
    chk(wr_count == p, "R3 write count", wr_count, p);
    chk(bptr == used, "R6 buffers taken", bptr, used);
    chk(in_ptr == len, "R8/R12 input consumed", in_ptr, len);
    chk(got_ovf == (p < t), "R8 overflow flag", got_ovf, (p < t));
    chk(got_stat == (16'hA000 | {15'd0, bc}), "R9 status", got_stat, 16'hA000 | {15'd0, bc});
    chk(got_irq, "R9 irq", got_irq, 1);
  endtask

  task automatic fill_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + seed) | 1);
  endtask

  task automatic t_reset();
    chk(idle_o == 1, "R1 idle", idle_o, 1);
    chk({in_ready_o, buf_ready_o, wr_valid_o, cnt_valid_o, done_o} == 0,
        "R1 quiet", {in_ready_o, buf_ready_o, wr_valid_o, cnt_valid_o, done_o}, 0);
  endtask

  task automatic t_short_pad();
    fill_frame(20, 3); nbuf = 1; sz[0] = 16'h8000 | 16'd100;
    run(20, 32'hA1B2C3D4, 0, 0, 0, 0);
    check_frame(20, 32'hA1B2C3D4, 0);
    chk(mem[0][20] == 8'h00 && mem[0][59] == 8'h00, "R5 zero pad", mem[0][20], 0);
    chk(mem[0][60] == 8'hA1 && mem[0][63] == 8'hD4, "R4 fcs order", mem[0][60], 8'hA1);
    chk(cntw[0] == 16'hC040, "R6 single buffer", cntw[0], 16'hC040);
  endtask

  task automatic t_split_fcs();
    fill_frame(70, 11); nbuf = 2; sz[0] = 16'd72; sz[1] = 16'h8000 | 16'd10;
    run(70, 32'h11223344, 1, 0, 0, 1);
    check_frame(70, 32'h11223344, 1);
    chk(mem[0][71] == 8'h22 && mem[1][0] == 8'h33 && mem[1][1] == 8'h44,
        "R3 fcs split", mem[1][0], 8'h33);
    chk(cntw[1] == 16'hC002, "R12 stalled run count", cntw[1], 16'hC002);
  endtask

  task automatic t_exact_fit();
    fill_frame(64, 5); nbuf = 3;
    sz[0] = 16'h4022; sz[1] = 16'd34; sz[2] = 16'h8000 | 16'd50;
    run(64, 32'hCAFEF00D, 0, 0, 0, 0);
    check_frame(64, 32'hCAFEF00D, 0);
    chk(cntw[0] == 16'h4022, "R2 bit 14 ignored", cntw[0], 16'h4022);
    chk(!cnt_seen[2] && bptr == 2, "R6 no fetch after end", bptr, 2);
  endtask

  task automatic t_zero_cap();
    fill_frame(30, 9); nbuf = 2; sz[0] = 16'h0000; sz[1] = 16'h8000 | 16'd64;
    run(30, 32'h0F1E2D3C, 0, 0, 0, 0);
    check_frame(30, 32'h0F1E2D3C, 0);
    chk(cntw[0] == 16'h4000, "R7 zero capacity", cntw[0], 16'h4000);
  endtask

  task automatic t_overflow();
    fill_frame(80, 13); nbuf = 2; sz[0] = 16'd30; sz[1] = 16'h8000 | 16'd20;
    run(80, 32'hDEADBEEF, 0, 0, 0, 1);
    check_frame(80, 32'hDEADBEEF, 0);
    chk(got_ovf && cntw[1] == 16'h4014, "R8 truncated last word", cntw[1], 16'h4014);
    chk(in_ptr == 80, "R8 drain", in_ptr, 80);
    fill_frame(60, 2); nbuf = 1; sz[0] = 16'h8000 | 16'd62;
    run(60, 32'h55667788, 0, 0, 0, 0);
    check_frame(60, 32'h55667788, 0);
    chk(got_ovf && cntw[0] == 16'h403E, "R8 truncated in fcs", cntw[0], 16'h403E);
  endtask

  task automatic t_halt(input bit su);
    fill_frame(10, 1); nbuf = 1; sz[0] = 16'h8000 | 16'd64;
    run(10, 32'h01020304, 0, su, !su, 0);
    check_frame(10, 32'h01020304, 0);
    if (su) chk(got_rnr == 1, "R10 rnr event", got_rnr, 1);
    else    chk(got_rnr == 0, "R11 no rnr on end of list", got_rnr, 0);
    chk(halt_o && !idle_o, su ? "R10 halted" : "R11 halted", halt_o, 1);
    @(negedge clk_i);
    start_i = 1; in_valid_i = 1; buf_valid_i = 1;
    @(negedge clk_i);
    start_i = 0;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(!in_ready_o && !buf_ready_o && !wr_valid_o, su ? "R10 start ignored" : "R11 start ignored",
          {in_ready_o, buf_ready_o}, 0);
      @(negedge clk_i);
    end
    in_valid_i = 0; buf_valid_i = 0;
    resume_i = 1;
    @(negedge clk_i);
    resume_i = 0;
    #1;
    chk(idle_o && !halt_o, su ? "R10 resume" : "R11 resume", idle_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_short_pad();
    t_split_fcs();
    t_exact_fit();
    t_zero_cap();
    t_overflow();
    t_halt(1'b1);
    t_halt(1'b0);
    finish_run();
  end
endmodule